// File: doc/BRIEF.md
# Frame Sync and Transmit Gating Controller

This block paces a camera at a fixed frame rate and decides, once per frame, whether image data may be sent. It drives an active-low frame sync output that falls at the start of every frame and stays low for a fixed time. After each falling edge it waits a fixed hold-off, then watches an external gating level for a qualification window. Transmission is allowed for the coming frame only if the gating level stayed high for the whole window.

The outcome is applied to a transmit-enable level at the close of the window and held there until the next frame's decision. A one-cycle decision strobe marks every update, so downstream logic can start or stop on a frame boundary. All durations are given in milliseconds and turned into cycle counts from the clock frequency parameter. The defaults give 25 frames per second, a 5 ms sync-low time, a 2 ms hold-off and a 10 ms window.

Top module: `frame_gate_ctrl`

## Requirements
- R1: While `rst` is high, `sync_n` is 1, `tx_en` is 0 and `dec_stb` is 0.
- R2: Counting clock edges from the first edge after reset release as edge 0, after edge j the output `sync_n` is 0 when (j mod F) < L and 1 otherwise. F is the frame length in cycles and L is the sync-low time in cycles. The first falling edge comes at edge 0.
- R3: `gate_in` passes through a two-stage synchroniser. A level driven before edge j is judged at frame phase (j+2) mod F. The window covers phases D through D+W-1, where D is the hold-off and W is the window length, both in cycles.
- R4: If every judged sample in the window is high, `tx_en` becomes 1 at that frame's decision.
- R5: A single low sample anywhere in the window makes `tx_en` 0 at that frame's decision.
- R6: Low levels on `gate_in` that fall outside the window have no effect on the decision.
- R7: The decision takes effect after the edge at phase D+W, which is D+W cycles after the falling edge of `sync_n`. `tx_en` keeps its value at all other times.
- R8: `dec_stb` is high for exactly one cycle per frame, in the cycle where `tx_en` takes its new decision. It is never high while `sync_n` is low.
- R9: Every duration in cycles equals its millisecond parameter times CLK_HZ/1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_in | input | 1 | Asynchronous gating level from outside |
| sync_n | output | 1 | Active-low frame sync |
| tx_en | output | 1 | Transmit permitted for the current frame |
| dec_stb | output | 1 | One-cycle pulse on each decision |

## Verification
`sync_n` follows the frame phase one edge later. A gating level is judged two edges after it is driven, and `tx_en` and `dec_stb` appear one edge after the phase D+W is reached. The bench drives `gate_in` at each falling clock edge, before edge j. After edge j it checks all three outputs against values it computes from j mod F, the same falling-edge sampling it uses for every check. The bench sweeps a single-cycle low glitch across every position from four cycles before the window to beyond its end. Each glitch sits in its own frame, so both window boundaries are covered to the exact cycle.

// File: rtl/frame_gate_ctrl.sv
module frame_gate_ctrl #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int FRAME_MS    = 40,
  parameter int SYNC_LOW_MS = 5,
  parameter int HOLDOFF_MS  = 2,
  parameter int QUAL_MS     = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_in,
  output logic sync_n,
  output logic tx_en,
  output logic dec_stb
);
  localparam int CYC_MS    = CLK_HZ / 1000;
  localparam int FRAME_CYC = FRAME_MS * CYC_MS;
  localparam int LOW_CYC   = SYNC_LOW_MS * CYC_MS;
  localparam int QSTART    = HOLDOFF_MS * CYC_MS;
  localparam int QEND      = QSTART + QUAL_MS * CYC_MS;
  localparam int CW        = $clog2(FRAME_CYC);

  localparam logic [CW-1:0] FRAME_LAST = CW'(FRAME_CYC - 1);
  localparam logic [CW-1:0] LOW_END    = CW'(LOW_CYC);
  localparam logic [CW-1:0] WIN_FIRST  = CW'(QSTART);
  localparam logic [CW-1:0] WIN_STOP   = CW'(QEND);

  logic [CW-1:0] fcnt;
  logic gate_s1, gate_s2, qual_ok;

  wire in_window = (fcnt >= WIN_FIRST) && (fcnt < WIN_STOP);
  wire decide    = (fcnt == WIN_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt    <= '0;
      sync_n  <= 1'b1;
      gate_s1 <= 1'b0;
      gate_s2 <= 1'b0;
      qual_ok <= 1'b1;
      tx_en   <= 1'b0;
      dec_stb <= 1'b0;
    end else begin
      fcnt    <= (fcnt == FRAME_LAST) ? '0 : fcnt + 1'b1;
      sync_n  <= (fcnt >= LOW_END);
      gate_s1 <= gate_in;
      gate_s2 <= gate_s1;
      if (fcnt == WIN_FIRST)
        qual_ok <= gate_s2;
      else if (in_window)
        qual_ok <= qual_ok & gate_s2;
      dec_stb <= decide;
      if (decide)
        tx_en <= qual_ok;
    end
  end

  // R2
  sync_fall_at_frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_n) |-> (fcnt == CW'(1)));

  // R7
  tx_hold_between_decisions_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_stb |-> $stable(tx_en));

  // R8
  strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    dec_stb |=> !dec_stb);

  // R8
  strobe_outside_sync_low_chk: assert property (@(posedge clk) disable iff (rst)
    dec_stb |-> sync_n);

  // R3
  window_counter_sane_chk: assert property (@(posedge clk) disable iff (rst)
    fcnt <= FRAME_LAST);
endmodule

// File: tb/test_frame_gate_ctrl.sv
module test_frame_gate_ctrl;
  localparam int CLK_HZ = 8000;
  localparam int FR_MS = 40, LO_MS = 5, HO_MS = 2, Q_MS = 10;
  localparam int CPM = CLK_HZ / 1000;
  localparam int F = FR_MS * CPM;
  localparam int L = LO_MS * CPM;
  localparam int D = HO_MS * CPM;
  localparam int W = Q_MS * CPM;
  localparam int NSWEEP = W + 6;
  localparam int NFR = 5 + NSWEEP;

  logic clk = 1'b0, rst = 1'b1, gate_in = 1'b0;
  logic sync_n, tx_en, dec_stb;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  frame_gate_ctrl #(.CLK_HZ(CLK_HZ), .FRAME_MS(FR_MS), .SYNC_LOW_MS(LO_MS),
                    .HOLDOFF_MS(HO_MS), .QUAL_MS(Q_MS)) i_frame_gate_ctrl (
    .clk(clk), .rst(rst), .gate_in(gate_in),
    .sync_n(sync_n), .tx_en(tx_en), .dec_stb(dec_stb));

  task automatic chk(input string req, input logic act, input logic exp, input int j);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s edge %0d: actual %b expected %b", req, j, act, exp);
    end
  endtask

  function automatic logic drive_val(int j);
    int f = j / F, p = j % F, gp;
    if (f == 1) return 1'b0;
    if (f == 3) return (p >= D + W / 2) ? 1'b0 : 1'b1;
    if (f >= 5) begin
      gp = D - 4 + (f - 5);
      return (p == gp) ? 1'b0 : 1'b1;
    end
    return 1'b1;
  endfunction

  function automatic logic exp_dec(int f);
    int gp;
    if (f == 1 || f == 3) return 1'b0;
    if (f >= 5) begin
      gp = D - 4 + (f - 5);
      return (gp >= D - 2 && gp < D + W - 2) ? 1'b0 : 1'b1;
    end
    return 1'b1;
  endfunction

  function automatic string dec_req(int f);
    if (f == 1 || f == 3) return "R5";
    if (f >= 5) return exp_dec(f) ? "R6 R3" : "R5 R3";
    return "R4";
  endfunction

  initial begin
    logic exp_tx;
    exp_tx = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk("R1 sync", sync_n, 1'b1, -1);
    chk("R1 tx", tx_en, 1'b0, -1);
    chk("R1 stb", dec_stb, 1'b0, -1);
    rst = 1'b0;
    for (int j = 0; j < NFR * F; j++) begin
      int p, f;
      p = j % F;
      f = j / F;
      gate_in = drive_val(j);
      @(posedge clk);
      @(negedge clk);
      // R2 R9: cycle counts derived from CLK_HZ/1000
      chk("R2 R9 sync", sync_n, (p >= L) ? 1'b1 : 1'b0, j);
      chk("R8 stb", dec_stb, (p == D + W) ? 1'b1 : 1'b0, j);
      if (p == D + W) begin
        exp_tx = exp_dec(f);
        chk(dec_req(f), tx_en, exp_tx, j);
      end else begin
        chk("R7 hold", tx_en, exp_tx, j);
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule